// File: doc/BRIEF.md
# Byte-Lane Static RAM Access Controller

This block sits between a clocked system and an external asynchronous static RAM organised as 128K words of 16 bits, with one enable per byte. A single request carries an address, write data, a two-bit lane mask and a direction flag. The controller turns that request into a strobe sequence on the memory pins. The sequence holds every nanosecond limit of the memory: write-enable pulse width, address and data setup to the end of the write, and access time from chip enable, address and output enable. Each limit is converted to whole clock cycles from a clock-period parameter, always rounding up.

The system side uses a ready/valid style. `req_ready` is high only while no access is running, and a one-cycle `rsp_valid` marks completion. A completed read returns the captured lanes on `rsp_rdata`. The memory side has no bidirectional pin. The write data, a drive-enable for an external tri-state buffer and the sampled bus value are kept as three separate signals, so the controller never drives the bus in the same cycle that output enable is asserted.

Top module: `sram_byte_ctrl`

## Requirements
- R1: `req_ready` is high exactly when no access is in progress. A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and `req_ready` stays low while chip enable is low.
- R2: During a write, chip enable is low and write enable pulses low. Mask bit 0 drives the low-byte enable (bits 7:0) low and mask bit 1 drives the high-byte enable (bits 15:8) low. Write enable is never low unless chip enable and at least one byte enable are low.
- R3: Write enable stays low for at least the pulse-width limit (50 ns by default). When write enable rises, the address has been stable for at least 60 ns and the write data for at least 30 ns.
- R4: A write keeps chip enable low for 1 setup cycle, then Np = max(ceil(50/T), ceil(30/T), ceil(60/T)-1) pulse cycles, then Nr = max(1, ceil(70/T)-1-Np) recovery cycles, where T is the clock period in ns. `rsp_valid` is high in the cycle after recovery, which gives 6 cycles after acceptance at T = 20.
- R5: During a read, chip enable and output enable are low, write enable is high and the drive-enable is low. The byte enables follow the mask as in R2.
- R6: A read holds its strobes for Na = max(ceil(70/T)-1, ceil(70/T), ceil(35/T)) cycles and samples the bus on the last one. One release cycle follows, and `rsp_valid` comes in the cycle after that (6 cycles after acceptance at T = 20). Unmasked lanes return zero. `rsp_rdata` holds its value until the next read completes.
- R7: The drive-enable is high only during write states. Output enable is never low while the drive-enable is high, or in the cycle just after it was high.
- R8: A request with mask 0 leaves every strobe inactive and completes with `rsp_valid` in the cycle after acceptance. Memory contents are unchanged.
- R9: During and just after reset, chip, write, output and byte enables are all high, the drive-enable is low, `rsp_valid` is low and `req_ready` is high.
- R10: The address on the memory pins does not change while chip enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select: bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Data of the last read, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low-byte enable, active low |
| mem_ub_n | output | 1 | High-byte enable, active low |
| mem_dq_out | output | 16 | Data to drive onto the memory bus |
| mem_dq_oe | output | 1 | Drive-enable for the bus buffer |
| mem_dq_in | input | 16 | Sampled memory bus |

## Verification
On every clock the assertions check the strobe relations: write enable only inside a chip and byte enable window, output enable never low together with write enable, no bus drive next to output enable, a stable address under chip enable, a quiet memory after a mask-0 request, and a write pulse long enough when converted back to nanoseconds. The bench's memory model stamps each pin change in time. From those stamps the scenarios show the address and data setup at the end of each write, that reads sample only after the access times, the exact response latencies, lane merging on partial writes, zeroed unselected read lanes and that `rsp_rdata` is held across later writes.

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl #(
  parameter int ADDR_W   = 17,
  parameter int CLK_NS   = 20,
  parameter int T_WC_NS  = 70,
  parameter int T_PWE_NS = 50,
  parameter int T_AW_NS  = 60,
  parameter int T_DW_NS  = 30,
  parameter int T_RC_NS  = 70,
  parameter int T_AA_NS  = 70,
  parameter int T_OE_NS  = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);

  function automatic int ns2cyc(input int ns);
    return (ns <= 0) ? 0 : (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_PULSE = imax(1, imax(ns2cyc(T_PWE_NS),
                                imax(ns2cyc(T_DW_NS), ns2cyc(T_AW_NS) - 1)));
  localparam int N_REC   = imax(1, ns2cyc(T_WC_NS) - 1 - N_PULSE);
  localparam int N_ACC   = imax(1, imax(ns2cyc(T_RC_NS) - 1,
                                imax(ns2cyc(T_AA_NS), ns2cyc(T_OE_NS))));
  localparam int N_MAX   = imax(N_PULSE, imax(N_REC, N_ACC));
  localparam int CNT_W   = $clog2(N_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WR_SETUP, S_WR_PULSE, S_WR_RECOVER, S_RD_ACCESS, S_RD_CAPTURE
  } state_t;

  state_t            state, nxt;
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic [1:0]        mask_q;
  logic [15:0]       rdata_q;
  logic              done_q;

  wire cnt_zero   = (cnt == '0);
  wire accept     = (state == S_IDLE) && req_valid;
  wire null_req   = accept && (req_mask == 2'b00);
  wire [1:0] lane = (state == S_IDLE) ? req_mask : mask_q;
  wire nxt_wr     = (nxt == S_WR_SETUP) || (nxt == S_WR_PULSE) || (nxt == S_WR_RECOVER);
  wire nxt_act    = nxt_wr || (nxt == S_RD_ACCESS);
  wire capture    = (state == S_RD_ACCESS) && cnt_zero;

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt_zero ? cnt : cnt - 1'b1;
    case (state)
      S_IDLE:
        if (req_valid && req_mask != 2'b00) begin
          nxt     = req_write ? S_WR_SETUP : S_RD_ACCESS;
          cnt_nxt = req_write ? '0 : CNT_W'(N_ACC - 1);
        end
      S_WR_SETUP: begin
        nxt     = S_WR_PULSE;
        cnt_nxt = CNT_W'(N_PULSE - 1);
      end
      S_WR_PULSE:
        if (cnt_zero) begin
          nxt     = S_WR_RECOVER;
          cnt_nxt = CNT_W'(N_REC - 1);
        end
      S_WR_RECOVER:
        if (cnt_zero) nxt = S_IDLE;
      S_RD_ACCESS:
        if (cnt_zero) nxt = S_RD_CAPTURE;
      S_RD_CAPTURE:
        nxt = S_IDLE;
      default:
        nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      mask_q     <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      rdata_q    <= '0;
      done_q     <= 1'b0;
    end else begin
      state     <= nxt;
      cnt       <= cnt_nxt;
      mem_ce_n  <= !nxt_act;
      mem_we_n  <= !(nxt == S_WR_PULSE);
      mem_oe_n  <= !(nxt == S_RD_ACCESS);
      mem_lb_n  <= !(nxt_act && lane[0]);
      mem_ub_n  <= !(nxt_act && lane[1]);
      mem_dq_oe <= nxt_wr;
      done_q    <= null_req || (state == S_RD_CAPTURE) ||
                   ((state == S_WR_RECOVER) && cnt_zero);
      if (accept) begin
        mask_q     <= req_mask;
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture)
        rdata_q <= {mask_q[1] ? mem_dq_in[15:8] : 8'h00,
                    mask_q[0] ? mem_dq_in[7:0]  : 8'h00};
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = done_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_byte_ctrl_chk.sv
module sram_byte_ctrl_chk #(
  parameter int ADDR_W   = 17,
  parameter int CLK_NS   = 20,
  parameter int T_PWE_NS = 50
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_mask,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              mem_dq_oe
);

  logic [15:0] we_run;

  always_ff @(posedge clk) begin
    if (!rst_n)         we_run <= '0;
    else if (!mem_we_n) we_run <= we_run + 1'b1;
    else                we_run <= '0;
  end

  assert_ready_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  assert_we_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && (!mem_lb_n || !mem_ub_n)));

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (32'(we_run) * CLK_NS >= T_PWE_NS));

  assert_read_we_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !$past(mem_dq_oe));

  assert_null_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mask == 2'b00) |=> (mem_ce_n && mem_we_n && mem_oe_n));

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_byte_ctrl sram_byte_ctrl_chk #(
  .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .T_PWE_NS(T_PWE_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mask(req_mask), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
  .mem_ub_n(mem_ub_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_byte_ctrl.sv
`timescale 1ns/1ps
module test_sram_byte_ctrl;
  localparam int AW = 17;
  localparam int T  = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_mask = '0;
  logic          req_ready, rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0]   mem_dq_out;
  logic [15:0]   mem_dq_in = 16'hBAD0;

  int checks = 0, errors = 0;
  bit done = 0;
  bit mon_r1_bad = 0, mon_r7_bad = 0;

  logic [15:0] shadow [logic [AW-1:0]];
  realtime t_we_fall = 0, t_addr = 0, t_data = 0, t_ce_fall = 0, t_oe_fall = 0;

  always #(T/2) clk = ~clk;

  sram_byte_ctrl i_sram_byte_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int cyc(input int ns);
    return (ns <= 0) ? 0 : (ns + T - 1) / T;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Memory model: timestamps on pin changes
  always @(negedge mem_we_n) t_we_fall = $realtime;
  always @(negedge mem_ce_n) t_ce_fall = $realtime;
  always @(negedge mem_oe_n) t_oe_fall = $realtime;
  always @(mem_addr)         t_addr    = $realtime;
  always @(mem_dq_out)       t_data    = $realtime;

  always @(posedge mem_we_n) begin
    if (rst_n && mem_ce_n === 1'b0) begin
      realtime now;
      logic [15:0] old;
      now = $realtime;
      chk(now - t_we_fall >= 50.0, "R3 we pulse ns", 32'(int'(now - t_we_fall)), 32'd50);
      chk(now - t_addr >= 60.0, "R3 addr setup ns", 32'(int'(now - t_addr)), 32'd60);
      chk(now - t_data >= 30.0, "R3 data setup ns", 32'(int'(now - t_data)), 32'd30);
      chk(mem_dq_oe === 1'b1, "R2 bus driven in write", 32'(mem_dq_oe), 32'd1);
      old = shadow.exists(mem_addr) ? shadow[mem_addr] : 16'h0000;
      if (!mem_lb_n) old[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) old[15:8] = mem_dq_out[15:8];
      shadow[mem_addr] = old;
    end
  end

  always begin
    #1;
    if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1 &&
        ($realtime - t_ce_fall >= 70.0) && ($realtime - t_oe_fall >= 35.0) &&
        ($realtime - t_addr >= 70.0)) begin
      logic [15:0] v;
      v = shadow.exists(mem_addr) ? shadow[mem_addr] : 16'h0000;
      mem_dq_in = {mem_ub_n ? 8'hEE : v[15:8], mem_lb_n ? 8'hEE : v[7:0]};
    end else begin
      mem_dq_in = 16'hBAD0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ce_n === 1'b0 && req_ready === 1'b1) mon_r1_bad = 1;
      if (mem_oe_n === 1'b0 && mem_dq_oe === 1'b1) mon_r7_bad = 1;
    end
  end

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
  endtask

  function automatic logic [AW-1:0] addr_of(input int i);
    case (i)
      0: return '0;
      1: return 17'h1FFFF;
      2: return 17'h10000;
      3: return 17'h0FFFF;
      default: return AW'(i * 32'h0A3B7);
    endcase
  endfunction

  function automatic logic [15:0] data_of(input logic [AW-1:0] a, input logic [15:0] salt);
    return 16'(32'(a) * 32'h9E37) ^ salt;
  endfunction

  initial begin
    int np, nr, na, exp_wr, exp_rd, lat;
    logic [15:0] rd, ref_v, held;
    np = mx(1, mx(cyc(50), mx(cyc(30), cyc(60) - 1)));
    nr = mx(1, cyc(70) - 1 - np);
    na = mx(1, mx(cyc(70) - 1, mx(cyc(70), cyc(35))));
    exp_wr = 1 + np + nr + 1;
    exp_rd = na + 1 + 1;

    repeat (3) @(negedge clk);
    // R9 reset state
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} === 5'h1F, "R9 strobes in reset",
        32'({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}), 32'h1F);
    chk(mem_dq_oe === 1'b0 && rsp_valid === 1'b0, "R9 drive/rsp in reset",
        32'({mem_dq_oe, rsp_valid}), 32'd0);
    chk(req_ready === 1'b1, "R9 ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1;
    @(negedge clk);
    chk(mem_ce_n === 1'b1 && req_ready === 1'b1, "R9 idle after reset",
        32'({mem_ce_n, req_ready}), 32'h3);

    // R2 R4: full writes
    for (int i = 0; i < 12; i++) begin
      do_req(1, addr_of(i), data_of(addr_of(i), 16'h0000), 2'b11, rd, lat);
      chk(lat == exp_wr, "R4 write latency", 32'(lat), 32'(exp_wr));
    end

    // R5 R6: reads under every nonzero mask
    for (int i = 0; i < 12; i++) begin
      for (int m = 1; m < 4; m++) begin
        ref_v = data_of(addr_of(i), 16'h0000);
        ref_v = {m[1] ? ref_v[15:8] : 8'h00, m[0] ? ref_v[7:0] : 8'h00};
        do_req(0, addr_of(i), 16'hFFFF, 2'(m), rd, lat);
        chk(lat == exp_rd, "R6 read latency", 32'(lat), 32'(exp_rd));
        chk(rd === ref_v, "R6 read data lanes", 32'(rd), 32'(ref_v));
      end
    end

    // R2: partial writes merge lanes
    for (int i = 0; i < 12; i++) begin
      logic [15:0] base, nw;
      int m;
      m = (i % 2) + 1;
      base = data_of(addr_of(i), 16'h0000);
      nw = data_of(addr_of(i), 16'h5A3C);
      do_req(1, addr_of(i), nw, 2'(m), rd, lat);
      chk(lat == exp_wr, "R4 partial write latency", 32'(lat), 32'(exp_wr));
      ref_v = (m == 1) ? {base[15:8], nw[7:0]} : {nw[15:8], base[7:0]};
      do_req(0, addr_of(i), 16'h0000, 2'b11, rd, lat);
      chk(rd === ref_v, "R2 lane merge", 32'(rd), 32'(ref_v));
    end

    // R8: mask 0 write and read complete at once, memory untouched
    held = rsp_rdata;
    do_req(1, addr_of(0), 16'h1234, 2'b00, rd, lat);
    chk(lat == 1, "R8 null write latency", 32'(lat), 32'd1);
    do_req(0, addr_of(0), 16'h0000, 2'b00, rd, lat);
    chk(lat == 1, "R8 null read latency", 32'(lat), 32'd1);
    chk(rd === held, "R8 null read keeps rdata", 32'(rd), 32'(held));
    ref_v = {data_of(addr_of(0), 16'h5A3C)[15:8] & 8'h00 | data_of(addr_of(0), 16'h0000)[15:8],
             data_of(addr_of(0), 16'h5A3C)[7:0]};
    do_req(0, addr_of(0), 16'h0000, 2'b11, rd, lat);
    chk(rd === ref_v, "R8 memory unchanged", 32'(rd), 32'(ref_v));

    // R6: rdata held across a write and idle cycles
    held = rd;
    do_req(1, addr_of(5), 16'hC0DE, 2'b11, rd, lat);
    repeat (3) @(negedge clk);
    chk(rsp_rdata === held, "R6 rdata held", 32'(rsp_rdata), 32'(held));

    // R7: write immediately followed by read of same word
    do_req(1, addr_of(6), 16'h7E81, 2'b11, rd, lat);
    do_req(0, addr_of(6), 16'h0000, 2'b11, rd, lat);
    chk(rd === 16'h7E81, "R7 write-then-read", 32'(rd), 32'h7E81);

    chk(!mon_r1_bad, "R1 ready low while chip enabled", 32'(mon_r1_bad), 32'd0);
    chk(!mon_r7_bad, "R7 no drive under output enable", 32'(mon_r7_bad), 32'd0);
    chk(mem_ce_n === 1'b1 && mem_dq_oe === 1'b0, "R10 quiet at end",
        32'({mem_ce_n, mem_dq_oe}), 32'h2);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(T * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule